// File: doc/BRIEF.md
# Privileged Trap Entry Sequencer

This block decides where the processor goes next when an exceptional event is taken and when a return-from-exception is executed. For an event it forms a handler address from a base register plus a fixed per-cause offset. It saves a restart address in its own exception-address register, and it asks for privileged mode to be entered when the interrupted code was not already privileged. Privileged mode is encoded in bit 0 of the program counter. All handler offsets have bit 0 set, so handler code runs privileged.

A return-from-exception executed in privileged mode redirects to the saved address. It requests an exit from privileged mode only when bit 0 of that address is clear. Executed outside privileged mode, the return is illegal: it is converted into an unimplemented-opcode event. Every request is registered, and the outputs appear one clock after the request is sampled. Choosing among simultaneous fault sources is left to the logic upstream, which presents one cause code at a time.

Top module: `trap_entry_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `redirect`, `exc_addr_upd`, `enter_priv`, `leave_priv` and `illegal_op` are 0 and `exc_addr` is 0.
- R2: An event sampled with `ev_valid`=1 gives, one cycle later, `redirect`=1 and `new_pc` = `priv_base` + offset. The offset comes from `ev_code` as follows:
  - code 0 gives 0x0001 (reset)
  - code 1 gives 0x0401 (machine check)
  - codes 2 and 15 give 0x0501 (arithmetic and integer overflow)
  - code 3 gives 0x0101 (interrupt)
  - code 4 gives 0x0201
  - code 5 gives 0x0281
  - code 6 gives 0x0301
  - codes 7 and 8 give 0x0381
  - codes 9 and 10 give 0x0181
  - code 11 gives 0x0081
  - code 12 gives 0x0481 (unimplemented opcode)
  - code 13 gives 0x0581
  - code 14 gives 0x2001 (privileged call)
- R3: Every redirect presents `new_npc` = `new_pc` + 4, modulo 2^W.
- R4: An event loads `exc_addr` with the sampled `cur_pc` and pulses `exc_addr_upd`, except that code 3 taken with `cur_pc[0]`=1 leaves `exc_addr` unchanged with `exc_addr_upd`=0.
- R5: For codes 2, 14 and 15 the saved address is `cur_pc` + 4, so the faulting instruction is skipped.
- R6: `enter_priv` pulses with a redirect exactly when the sampled `cur_pc[0]` was 0 and the redirect is an event or an illegal return.
- R7: A return request with `cur_pc[0]`=1 and no event redirects to the current `exc_addr`, with `new_npc` = `exc_addr` + 4. It leaves `exc_addr` unchanged.
- R8: A legal return pulses `leave_priv` only when bit 0 of `exc_addr` is 0.
- R9: A return request with `cur_pc[0]`=0 pulses `illegal_op` and is handled as event code 12 taken at `cur_pc`.
- R10: When `ev_valid` and `rfe_req` are sampled together, the event is taken and the return request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | An event is taken this cycle |
| ev_code | input | 4 | Cause code of the event |
| cur_pc | input | W | PC of the instruction at the event; bit 0 = privileged |
| priv_base | input | W | Base address of the handler area |
| rfe_req | input | 1 | Return-from-exception executed this cycle |
| redirect | output | 1 | New PC pair valid this cycle |
| new_pc | output | W | Next program counter |
| new_npc | output | W | Following program counter |
| exc_addr | output | W | Saved exception restart address |
| exc_addr_upd | output | 1 | Exception-address register was loaded |
| enter_priv | output | 1 | Request to enter privileged mode |
| leave_priv | output | 1 | Request to leave privileged mode |
| illegal_op | output | 1 | Return outside privileged mode was rejected |

## Verification
The assertions assume that the inputs are settled at each rising edge and that `priv_base` is held steady between a request and the redirect that follows it, because the handler-address check looks back one cycle at the base. The bench changes inputs only on the falling edge. It keeps each request to a single cycle followed by an idle cycle, so each redirect is tied to one request. It sweeps every cause code, both privilege states and two base values, one of which makes the sum wrap. It also covers the return cases that depend on bit 0 of the saved address.

// File: rtl/trap_entry_seq.sv
module trap_entry_seq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev_valid,
  input  logic [3:0]   ev_code,
  input  logic [W-1:0] cur_pc,
  input  logic [W-1:0] priv_base,
  input  logic         rfe_req,
  output logic         redirect,
  output logic [W-1:0] new_pc,
  output logic [W-1:0] new_npc,
  output logic [W-1:0] exc_addr,
  output logic         exc_addr_upd,
  output logic         enter_priv,
  output logic         leave_priv,
  output logic         illegal_op
);
  localparam logic [3:0] C_ARITH = 4'd2;
  localparam logic [3:0] C_INTR  = 4'd3;
  localparam logic [3:0] C_UNIMP = 4'd12;
  localparam logic [3:0] C_PCALL = 4'd14;
  localparam logic [3:0] C_IOVF  = 4'd15;

  function automatic logic [13:0] vec_off(input logic [3:0] c);
    case (c)
      4'd0:           vec_off = 14'h0001;
      4'd1:           vec_off = 14'h0401;
      4'd2, 4'd15:    vec_off = 14'h0501;
      4'd3:           vec_off = 14'h0101;
      4'd4:           vec_off = 14'h0201;
      4'd5:           vec_off = 14'h0281;
      4'd6:           vec_off = 14'h0301;
      4'd7, 4'd8:     vec_off = 14'h0381;
      4'd9, 4'd10:    vec_off = 14'h0181;
      4'd11:          vec_off = 14'h0081;
      4'd12:          vec_off = 14'h0481;
      4'd13:          vec_off = 14'h0581;
      default:        vec_off = 14'h2001;
    endcase
  endfunction

  logic         priv_now, bad_rfe, good_rfe, any_req, skip, keep, save;
  logic [3:0]   eff_code;
  logic [W-1:0] vec, target;

  assign priv_now = cur_pc[0];
  assign bad_rfe  = rfe_req && !ev_valid && !priv_now;
  assign good_rfe = rfe_req && !ev_valid && priv_now;
  assign any_req  = ev_valid || rfe_req;
  assign eff_code = ev_valid ? ev_code : C_UNIMP;
  assign vec      = priv_base + W'(vec_off(eff_code));
  assign target   = good_rfe ? exc_addr : vec;
  assign skip     = ev_valid && (ev_code == C_ARITH || ev_code == C_IOVF || ev_code == C_PCALL);
  assign keep     = ev_valid && ev_code == C_INTR && priv_now;
  assign save     = (ev_valid || bad_rfe) && !keep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect     <= 1'b0;
      new_pc       <= '0;
      new_npc      <= '0;
      exc_addr     <= '0;
      exc_addr_upd <= 1'b0;
      enter_priv   <= 1'b0;
      leave_priv   <= 1'b0;
      illegal_op   <= 1'b0;
    end else begin
      redirect     <= any_req;
      if (any_req) begin
        new_pc  <= target;
        new_npc <= target + W'(4);
      end
      if (save) exc_addr <= cur_pc + (skip ? W'(4) : W'(0));
      exc_addr_upd <= save;
      enter_priv   <= (ev_valid || bad_rfe) && !priv_now;
      leave_priv   <= good_rfe && !exc_addr[0];
      illegal_op   <= bad_rfe;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !redirect && !exc_addr_upd && !illegal_op) else $error("AST_RESET_QUIET"); // R1
  AST_NPC_STEP: assert property (@(posedge clk) disable iff (!rst_n) redirect |-> new_npc - new_pc == W'(4)) else $error("AST_NPC_STEP"); // R3
  AST_INTR_KEEP: assert property (@(posedge clk) disable iff (!rst_n) $past(keep) |-> $stable(exc_addr) && !exc_addr_upd) else $error("AST_INTR_KEEP"); // R4
  AST_ENTER_FROM_USER: assert property (@(posedge clk) disable iff (!rst_n) enter_priv |-> redirect && !$past(cur_pc[0])) else $error("AST_ENTER_FROM_USER"); // R6
  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(enter_priv && leave_priv)) else $error("AST_MODE_EXCL"); // R8
  AST_RFE_TARGET: assert property (@(posedge clk) disable iff (!rst_n) $past(good_rfe) |-> redirect && new_pc == $past(exc_addr) && $stable(exc_addr)) else $error("AST_RFE_TARGET"); // R7
  AST_ILLEGAL_VEC: assert property (@(posedge clk) disable iff (!rst_n) illegal_op |-> new_pc == $past(priv_base) + W'(14'h0481) && exc_addr == $past(cur_pc)) else $error("AST_ILLEGAL_VEC"); // R9
endmodule

// File: tb/tb_trap_entry_seq.sv
module tb_trap_entry_seq;
  localparam int W = 32;
  logic clk = 0, rst_n = 0, ev_valid = 0, rfe_req = 0;
  logic [3:0] ev_code = 0;
  logic [W-1:0] cur_pc = 0, priv_base = 0;
  logic redirect, exc_addr_upd, enter_priv, leave_priv, illegal_op;
  logic [W-1:0] new_pc, new_npc, exc_addr;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [W-1:0] m_exc = 0;

  always #10 clk = ~clk;

  trap_entry_seq #(.W(W)) dut (.*);

  task automatic chk(string r, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [W-1:0] off(input int c);
    case (c)
      0: return 'h1;     1: return 'h401;  2: return 'h501;  15: return 'h501;
      3: return 'h101;   4: return 'h201;  5: return 'h281;  6: return 'h301;
      7: return 'h381;   8: return 'h381;  9: return 'h181;  10: return 'h181;
      11: return 'h81;   12: return 'h481; 13: return 'h581; default: return 'h2001;
    endcase
  endfunction

  task automatic req(bit ev, int code, bit rfe, logic [W-1:0] pc);
    @(negedge clk);
    ev_valid = ev; ev_code = 4'(code); rfe_req = rfe; cur_pc = pc;
    @(posedge clk); #1;
    @(negedge clk);
    ev_valid = 0; rfe_req = 0;
  endtask

  task automatic check_event(int code, logic [W-1:0] pc, string tag);
    logic [W-1:0] v;
    bit kept;
    v = priv_base + off(code);
    kept = (code == 3) && pc[0];
    chk({"R2 new_pc ", tag}, new_pc, v);
    chk({"R3 new_npc ", tag}, new_npc, v + 4);
    chk({"R2 redirect ", tag}, W'(redirect), 1);
    if (!kept) m_exc = pc + ((code == 2 || code == 14 || code == 15) ? 4 : 0);
    chk({"R4 R5 exc_addr ", tag}, exc_addr, m_exc);
    chk({"R4 exc_addr_upd ", tag}, W'(exc_addr_upd), W'(!kept));
    chk({"R6 enter_priv ", tag}, W'(enter_priv), W'(!pc[0]));
    chk({"R8 leave_priv ", tag}, W'(leave_priv), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 redirect", W'(redirect), 0);
    chk("R1 exc_addr", exc_addr, 0);
    chk("R1 enter_priv", W'(enter_priv), 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R1 first cycle flags", W'({redirect, exc_addr_upd, enter_priv, leave_priv, illegal_op}), 0);

    for (int b = 0; b < 2; b++) begin
      priv_base = (b == 0) ? 32'h0001_0000 : 32'hFFFF_F000;
      for (int p = 0; p < 2; p++)
        for (int c = 0; c < 16; c++) begin
          logic [W-1:0] pc;
          pc = 32'h0040_1230 + 32'(c * 16) + 32'(p);
          @(negedge clk);
          ev_valid = 1; ev_code = 4'(c); cur_pc = pc;
          @(posedge clk); #1;
          check_event(c, pc, $sformatf("b%0d p%0d c%0d", b, p, c));
          @(negedge clk); ev_valid = 0;
        end
    end

    priv_base = 32'h0002_0000;
    req(1, 1, 0, 32'h1234_5678);
    check_event(1, 32'h1234_5678, "setup user save");
    req(0, 0, 1, 32'h0002_0401);
    chk("R7 return pc", new_pc, 32'h1234_5678);
    chk("R7 return npc", new_npc, 32'h1234_567C);
    chk("R7 exc kept", exc_addr, 32'h1234_5678);
    chk("R8 leave when bit0 clear", W'(leave_priv), 1);
    chk("R9 no illegal on legal return", W'(illegal_op), 0);

    req(1, 1, 0, 32'h0000_3003);
    check_event(1, 32'h0000_3003, "setup priv save");
    req(0, 0, 1, 32'h0002_0401);
    chk("R7 return pc priv", new_pc, 32'h0000_3003);
    chk("R8 no leave when bit0 set", W'(leave_priv), 0);

    req(0, 0, 1, 32'h0000_5000);
    chk("R9 illegal_op", W'(illegal_op), 1);
    chk("R9 vector", new_pc, 32'h0002_0481);
    chk("R9 exc_addr", exc_addr, 32'h0000_5000);
    chk("R9 enter_priv", W'(enter_priv), 1);
    m_exc = 32'h0000_5000;

    req(1, 6, 1, 32'h0000_7001);
    chk("R10 event wins pc", new_pc, 32'h0002_0301);
    chk("R10 exc_addr", exc_addr, 32'h0000_7001);
    chk("R10 no leave", W'(leave_priv), 0);
    chk("R10 no illegal", W'(illegal_op), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule